// File: doc/BRIEF.md
# Run-Length Capture Stream Decompressor

The block turns the compressed word stream read back from a stopped logic-analyzer capture buffer into a plain stream of samples, one per output beat. Each incoming word is `SAMPLE_W+1` bits wide. Its top bit is the kind flag. With the flag clear, the low `SAMPLE_W` bits are a new sample, and that sample is sent out once. With the flag set, the low bits are a run length: the number of further copies of the most recent sample to send out. Run lengths saturate at the all-ones value during capture, so a long idle stretch arrives as several capped runs separated by literals. The block needs no special handling for that case.

A host pushes words over a valid/ready handshake, but only while `enable` is high, which means the capture has stopped. Samples leave over a second valid/ready handshake. Each sample carries a flag that tells a literal beat from an expanded copy. A malformed stream raises a sticky format-error flag, and the offending word is dropped. A malformed stream is one with a run before any literal, two runs in a row, or a run of zero.

The controller has five states. `ST_NO_LIT` means no literal has been seen since reset. `ST_LIT_OUT` presents a literal beat. `ST_WAIT_LIT` follows a consumed literal, so a run is legal. `ST_EXPAND` sends run copies. `ST_WAIT_REP` follows a finished run, so only a literal is legal. The transitions are:
- `ST_NO_LIT`→`ST_LIT_OUT` on a literal.
- `ST_LIT_OUT`→`ST_LIT_OUT` on a literal accepted as the beat leaves.
- `ST_LIT_OUT`/`ST_WAIT_LIT`→`ST_EXPAND` on a legal run.
- `ST_LIT_OUT`→`ST_WAIT_LIT` when the beat leaves with no legal follow-on word.
- `ST_WAIT_LIT`/`ST_WAIT_REP`→`ST_LIT_OUT` on a literal.
- `ST_EXPAND`→`ST_WAIT_REP` when the last copy leaves.

Reset returns the controller to `ST_NO_LIT`.

Top module: `rle_expander`

## Requirements
- R1: A word accepted with bit `SAMPLE_W` = 0 is presented on the following cycle as one output beat: `out_sample` equals the word's bits `SAMPLE_W-1:0` and `out_repeat` = 0.
- R2: A legal run word (bit `SAMPLE_W` = 1) with count N (bits `SAMPLE_W-1:0`) yields exactly N beats of the held literal with `out_repeat` = 1. While `out_ready` stays high these beats occupy N consecutive cycles. `in_ready` returns high on the cycle after the last beat.
- R3: While run copies are being presented, `in_ready` is low.
- R4: A run word accepted before any literal since reset sets `fmt_error` and produces no beat.
- R5: A run word accepted directly after a run word sets `fmt_error` and is dropped.
- R6: A run word with count 0 sets `fmt_error` and is dropped. A dropped word leaves the sequence state unchanged, so a following nonzero run after a literal is still expanded.
- R7: `fmt_error` stays high until reset, and later legal words are still processed.
- R8: `in_ready` is low whenever `enable` is low. A run already being expanded continues to completion.
- R9: While `out_valid` is high and `out_ready` is low, the beat holds: `out_valid`, `out_sample` and `out_repeat` keep their values.
- R10: The all-ones count (2^`SAMPLE_W`-1) is a normal count and expands in full.
- R11: Synchronous reset (`rst` high) clears `out_valid`, `fmt_error`, the remaining count and the literal-seen state. A run word after reset is then an error.
- R12: With `out_ready` high, literal words stream at one per cycle. A literal is accepted in the same cycle the previous literal beat leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Capture stopped; input is accepted only while high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | SAMPLE_W+1 | Bit SAMPLE_W: 1 = run count, 0 = literal; low bits = value or count |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_sample | output | SAMPLE_W | Sample value |
| out_repeat | output | 1 | 0 = literal beat, 1 = expanded copy |
| fmt_error | output | 1 | Sticky malformed-stream flag |

## Verification
The bench builds the block with `SAMPLE_W` = 7, so a word is 8 bits and counts run from 1 to 127. This makes the whole count range reachable, including the saturated all-ones run. Every count from 1 to 127 is expanded with the consumer always ready, and the bench checks the cycle distance to the next accepted word. A second sweep over a spread of counts repeats the test under pseudo-random backpressure. The short word width also keeps each error ordering, the enable drop during expansion and the literal streaming rate cheap to exercise in sequence.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic [2:0] {
        ST_NO_LIT   = 3'd0,
        ST_LIT_OUT  = 3'd1,
        ST_WAIT_LIT = 3'd2,
        ST_EXPAND   = 3'd3,
        ST_WAIT_REP = 3'd4
    } rle_state_e;

endpackage

// File: rtl/rle_word_classify.sv
module rle_word_classify #(
    parameter int SAMPLE_W = 31
) (
    input  logic [SAMPLE_W:0]   word,
    output logic                is_run,
    output logic [SAMPLE_W-1:0] payload,
    output logic                zero_count
);

    always_comb begin
        is_run     = word[SAMPLE_W];
        payload    = word[SAMPLE_W-1:0];
        zero_count = (word[SAMPLE_W-1:0] == '0);
    end

endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (step && (remaining != '0)) begin
            remaining <= remaining - ONE;
        end
    end

    always_comb begin
        last = (remaining == ONE);
    end

endmodule

// File: rtl/rle_expander.sv
module rle_expander
    import rle_pkg::*;
#(
    parameter int SAMPLE_W = 31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W:0]   in_word,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_repeat,
    output logic                fmt_error
);

    localparam int WORD_W = SAMPLE_W + 1;

    rle_state_e state, state_n;

    logic                w_is_run;
    logic [SAMPLE_W-1:0] w_payload;
    logic                w_zero;
    logic                run_last;
    logic [SAMPLE_W-1:0] held_q;
    logic                err_q;

    logic accept, fire, lit_acc, run_acc, run_legal, run_bad;

    rle_word_classify #(.SAMPLE_W(SAMPLE_W)) u_classify (
        .word       (in_word[WORD_W-1:0]),
        .is_run     (w_is_run),
        .payload    (w_payload),
        .zero_count (w_zero)
    );

    rle_run_counter #(.CNT_W(SAMPLE_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (run_legal),
        .load_val (w_payload),
        .step     (fire && (state == ST_EXPAND)),
        .last     (run_last)
    );

    // handshake decode
    always_comb begin
        accept    = in_valid && in_ready;
        fire      = out_valid && out_ready;
        lit_acc   = accept && !w_is_run;
        run_acc   = accept && w_is_run;
        run_legal = run_acc && !w_zero &&
                    ((state == ST_LIT_OUT) || (state == ST_WAIT_LIT));
        run_bad   = run_acc && !run_legal;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_NO_LIT: begin
                if (lit_acc) state_n = ST_LIT_OUT;
            end
            ST_LIT_OUT: begin
                if (lit_acc)        state_n = ST_LIT_OUT;
                else if (run_legal) state_n = ST_EXPAND;
                else if (fire)      state_n = ST_WAIT_LIT;
            end
            ST_WAIT_LIT: begin
                if (lit_acc)        state_n = ST_LIT_OUT;
                else if (run_legal) state_n = ST_EXPAND;
            end
            ST_EXPAND: begin
                if (fire && run_last) state_n = ST_WAIT_REP;
            end
            ST_WAIT_REP: begin
                if (lit_acc) state_n = ST_LIT_OUT;
            end
            default: state_n = ST_NO_LIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_NO_LIT;
        else     state <= state_n;
    end

    // held literal and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (lit_acc) held_q <= w_payload;
            if (run_bad) err_q  <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        out_valid  = (state == ST_LIT_OUT) || (state == ST_EXPAND);
        out_repeat = (state == ST_EXPAND);
        out_sample = held_q;
        fmt_error  = err_q;
        unique case (state)
            ST_EXPAND:  in_ready = 1'b0;
            ST_LIT_OUT: in_ready = enable && out_ready;
            default:    in_ready = enable;
        endcase
    end

endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
    parameter int SAMPLE_W = 31
) (
    input logic                clk,
    input logic                rst,
    input logic                enable,
    input logic                in_valid,
    input logic                in_ready,
    input logic [SAMPLE_W:0]   in_word,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                out_repeat,
    input logic                fmt_error
);

    logic seen_lit;
    logic acc;

    always_comb acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)                        seen_lit <= 1'b0;
        else if (acc && !in_word[SAMPLE_W]) seen_lit <= 1'b1;
    end

    AST_LIT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (acc && !in_word[SAMPLE_W]) |=> (out_valid && !out_repeat &&
            out_sample == $past(in_word[SAMPLE_W-1:0]))); // R1

    AST_EXPAND_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_repeat) |-> !in_ready); // R3

    AST_RUN_BEFORE_LIT: assert property (@(posedge clk) disable iff (rst)
        (acc && in_word[SAMPLE_W] && !seen_lit) |=> (fmt_error && !out_valid)); // R4

    AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
        (acc && in_word[SAMPLE_W] && in_word[SAMPLE_W-1:0] == '0) |=> fmt_error); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        fmt_error |=> fmt_error); // R7

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !in_ready); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) &&
            $stable(out_repeat))); // R9

endmodule

bind rle_expander rle_expander_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .out_repeat (out_repeat),
    .fmt_error  (fmt_error)
);

// File: tb/test_rle_expander.sv
`timescale 1ns/1ps
module test_rle_expander;

    localparam int SW   = 7;
    localparam int MAXC = (1 << SW) - 1;
    localparam int QSZ  = 16384;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW:0]   in_word = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [SW-1:0] out_sample;
    logic          out_repeat;
    logic          fmt_error;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int exp_samp [QSZ];
    bit exp_rep  [QSZ];
    int exp_n = 0;
    int got_n = 0;

    bit m_lit = 0, m_lastrep = 0, m_err = 0;
    int m_held = 0;

    bit rnd_on = 0;
    logic [7:0] lfsr = 8'hA5;

    rle_expander #(.SAMPLE_W(SW)) i_rle_expander (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample),
        .out_repeat (out_repeat),
        .fmt_error  (fmt_error)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic push(input int s, input bit r);
        exp_samp[exp_n] = s;
        exp_rep[exp_n]  = r;
        exp_n++;
    endtask

    task automatic model_word(input logic [SW:0] w);
        int cnt;
        cnt = int'(w[SW-1:0]);
        if (!w[SW]) begin
            m_held = cnt; m_lit = 1; m_lastrep = 0;
            push(m_held, 0);
        end else if (!m_lit || m_lastrep || cnt == 0) begin
            m_err = 1;
        end else begin
            for (int i = 0; i < cnt; i++) push(m_held, 1);
            m_lastrep = 1;
        end
    endtask

    // called at posedge+1; returns at posedge+1 after the handshake edge
    task automatic send(input logic [SW:0] w);
        in_valid = 1'b1;
        in_word  = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        model_word(w);
    endtask

    task automatic drain(input string req);
        while (got_n < exp_n) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(got_n == exp_n, req, got_n, exp_n);
        chk(fmt_error == m_err, req, fmt_error, m_err);
        exp_n = 0; got_n = 0;
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_lit = 0; m_lastrep = 0; m_err = 0;
        exp_n = 0; got_n = 0;
        @(negedge clk);
        chk(!out_valid, "R11", out_valid, 0);
        chk(!fmt_error, "R11", fmt_error, 0);
        @(posedge clk); #1;
    endtask

    // consumer backpressure
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rnd_on) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                out_ready = lfsr[0] | lfsr[2];
            end else begin
                out_ready = 1'b1;
            end
        end
    end

    // output monitor
    initial begin
        bit prev_stall = 0;
        logic [SW-1:0] prev_samp = '0;
        logic prev_rep = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_stall = 0;
            end else begin
                if (prev_stall) begin
                    chk(out_valid && out_sample == prev_samp && out_repeat == prev_rep,
                        "R9", int'(out_sample), int'(prev_samp));
                end
                if (out_valid && out_repeat)
                    chk(!in_ready, "R3", in_ready, 0);
                if (out_valid && out_ready) begin
                    if (got_n < exp_n) begin
                        chk(int'(out_sample) == exp_samp[got_n] && out_repeat == exp_rep[got_n],
                            exp_rep[got_n] ? "R2" : "R1", int'(out_sample), exp_samp[got_n]);
                    end else begin
                        chk(1'b0, "R2 extra beat", int'(out_sample), -1);
                    end
                    got_n++;
                end
                prev_stall = out_valid && !out_ready;
                prev_samp  = out_sample;
                prev_rep   = out_repeat;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", got_n, exp_n);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0, k;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R11", out_valid, 0);
        chk(!fmt_error, "R11", fmt_error, 0);
        chk(!in_ready, "R8", in_ready, 0);
        @(posedge clk); #1;
        enable = 1'b1;

        // R4: run before literal, then R7 sticky with later literal processed
        send({1'b1, 7'd3});
        send({1'b0, 7'd21});
        drain("R4");
        chk(fmt_error, "R7", fmt_error, 1);
        do_reset();

        // R12: back-to-back literals
        @(posedge clk); #1;
        t0 = cyc;
        for (int i = 0; i < 20; i++) send({1'b0, 7'(i * 5 + 1)});
        chk(cyc - t0 == 20, "R12", cyc - t0, 20);
        drain("R12");

        // R2/R10: full count sweep, consumer always ready
        for (int n = 1; n <= MAXC; n++) begin
            send({1'b0, 7'(n ^ 7'h55)});
            send({1'b1, 7'(n)});
            k = 0;
            do begin @(negedge clk); k++; end while (!in_ready);
            chk(k == n + 1, (n == MAXC) ? "R10" : "R2", k, n + 1);
            @(posedge clk); #1;
            if (exp_n > QSZ - 300) drain("R2");
        end
        drain("R2");

        // R9/R10: backpressure sweep
        rnd_on = 1;
        for (int n = 1; n <= MAXC; n += 9) begin
            send({1'b0, 7'(n * 3)});
            send({1'b1, 7'(n)});
            send({1'b0, 7'(n + 2)});
            drain("R9");
        end
        send({1'b0, 7'h3C});
        send({1'b1, 7'(MAXC)});
        drain("R10");
        rnd_on = 0;

        // R5: run after run
        send({1'b0, 7'd9});
        send({1'b1, 7'd2});
        send({1'b1, 7'd3});
        drain("R5");
        chk(fmt_error, "R5", fmt_error, 1);
        do_reset();

        // R6: zero count dropped, sequence unchanged
        send({1'b0, 7'd44});
        send({1'b1, 7'd0});
        send({1'b1, 7'd2});
        drain("R6");
        chk(fmt_error, "R6", fmt_error, 1);
        do_reset();

        // R8: enable drop during expansion
        send({1'b0, 7'd17});
        send({1'b1, 7'd10});
        enable = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!in_ready, "R8", in_ready, 0);
        end
        chk(got_n == exp_n, "R8", got_n, exp_n);
        @(posedge clk); #1;
        enable = 1'b1;
        drain("R8");

        // R11: reset forgets literal
        send({1'b0, 7'd99});
        drain("R11");
        do_reset();
        send({1'b1, 7'd4});
        drain("R11");
        chk(fmt_error, "R11", fmt_error, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule